// File: doc/BRIEF.md
# Configurable-Select Programmable Word Memory

This block is a clocked model of an erasable, field-programmable word memory. Each word is 16 bits wide, and the address width is a parameter. The full device uses a 14-bit address, which gives 16384 words. A normal read port has three chip-select pins and one output-enable pin. The block drives its data bus only when all four of those pins sit at their configured active level. A small hidden configuration word sets the active level of each pin. Because the three select levels are independent, up to eight such memories can hang on the same three select wires. Each one answers at its own select combination.

A separate programming path writes and reads back the words. It uses a programming-mode input, a write strobe, a check (verify) strobe and a configuration-select input. The configuration-select input steers the strobes at the hidden configuration word instead of the array. An erase input returns the block to its blank state. Output drive is modelled as a data bus plus a drive flag: when the flag is low, the bus reads zero. All results are registered, so the clock cycle after the inputs are sampled stands in for the access and enable delays.

Top module: `cfgsel_word_mem`

## Requirements
- R1: The array holds 2**ADDR_W independent 16-bit words (ADDR_W = 14 in the full device), and each address selects its own word.
- R2: While `erase` is high, nothing is driven in the next cycle. Erase sets every array word to 0xFFFF and clears all four polarity bits to 0. Erase takes priority over every other input.
- R3: Every output is registered and appears one cycle after its inputs are sampled. Whenever `drive_o` is low, `dout` is 0. After reset, `drive_o`, `dout` and `err_o` are 0.
- R4: In the configuration word, bit 0 is the output-enable polarity and bits 12, 13 and 14 are the polarities of selects 0, 1 and 2. A polarity value of 1 means active high and 0 means active low. All other bits are ignored.
- R5: With `prog_mode` low, the block drives the addressed word only when `cs_in[0]`, `cs_in[1]`, `cs_in[2]` and `oe_in` all match their polarity bits. With the output enable active, exactly one of the eight select patterns drives.
- R6: With `prog_mode` high, `pgm_stb` high and `vfy_stb` low, the block writes `din` at `addr`, or into the configuration word when `cfg_sel` is high. Nothing is driven during a write.
- R7: With `prog_mode` high, `vfy_stb` high and `pgm_stb` low, the block drives the stored word whatever the selects and output enable are.
- R8: With `prog_mode` high and both strobes low (inhibit), nothing is written and nothing is driven.
- R9: With `cfg_sel` high, a write changes only the polarity bits, not the array. A verify returns the polarity bits at positions 0 and 12 to 14, with zeros elsewhere.
- R10: While `prog_mode` is low, the strobes have no effect: nothing is written.
- R11: When both strobes are high in programming mode, nothing is written. `err_o` is high for exactly that one following cycle.
- R12: With the selects held active and the address unchanged, read data stays stable on `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| addr | input | ADDR_W | Word address |
| cs_in | input | 3 | Chip-select pins, level set by polarity bits |
| oe_in | input | 1 | Output-enable pin, level set by polarity bit |
| prog_mode | input | 1 | Selects the programming path |
| pgm_stb | input | 1 | Write strobe (programming mode only) |
| vfy_stb | input | 1 | Read-back strobe (programming mode only) |
| cfg_sel | input | 1 | Steers write and read-back to the configuration word |
| erase | input | 1 | Restore the blank state |
| din | input | 16 | Word to program |
| dout | output | 16 | Data bus, zero when not driven |
| drive_o | output | 1 | High when the bus is driven |
| err_o | output | 1 | One-cycle pulse on a strobe conflict |

## Verification
The assertions assume that every input is held at a known 0 or 1 from time zero, including the cycles under reset. They also assume that inputs change only between clock edges. The stability property assumes that the array can change only through erase or a programming-mode write two cycles back.

The stimulus drives all inputs to zero before reset is released. It changes them only on the falling clock edge. It erases the part before the first read, so the hidden polarity register never holds unknown values.

// File: rtl/wmem_pkg.sv
package wmem_pkg;
    localparam int WORD_W  = 16;
    localparam int NUM_CS  = 3;
    localparam int OE_BIT  = 0;
    localparam int CS_BIT0 = 12;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [NUM_CS-1:0] cs_pol;
        logic              oe_pol;
    } pol_t;

    typedef enum logic [2:0] {
        OP_READ,
        OP_HOLD,
        OP_WRITE,
        OP_CHECK,
        OP_CLASH,
        OP_WIPE
    } op_e;

    function automatic pol_t pol_from_word(input word_t w);
        pol_t p;
        p.oe_pol = w[OE_BIT];
        for (int i = 0; i < NUM_CS; i++) p.cs_pol[i] = w[CS_BIT0 + i];
        return p;
    endfunction

    function automatic word_t word_from_pol(input pol_t p);
        word_t w;
        w = '0;
        w[OE_BIT] = p.oe_pol;
        for (int i = 0; i < NUM_CS; i++) w[CS_BIT0 + i] = p.cs_pol[i];
        return w;
    endfunction

    function automatic logic level_ok(input logic pin, input logic pol);
        return pin ~^ pol;
    endfunction
endpackage

// File: rtl/wmem_op_ctrl.sv
module wmem_op_ctrl
    import wmem_pkg::*;
(
    input  logic prog_mode,
    input  logic pgm_stb,
    input  logic vfy_stb,
    input  logic erase,
    output op_e  op
);
    // R2 erase wins, R10 strobes need programming mode, R11 clash
    always_comb begin
        if (erase)           op = OP_WIPE;
        else if (!prog_mode) op = OP_READ;
        else begin
            unique case ({pgm_stb, vfy_stb})
                2'b00:   op = OP_HOLD;
                2'b10:   op = OP_WRITE;
                2'b01:   op = OP_CHECK;
                default: op = OP_CLASH;
            endcase
        end
    end
endmodule

// File: rtl/wmem_sel_decode.sv
module wmem_sel_decode
    import wmem_pkg::*;
#(
    parameter int N = NUM_CS
) (
    input  logic [N-1:0] cs,
    input  logic         oe,
    input  logic [N-1:0] cs_pol,
    input  logic         oe_pol,
    output logic         sel_ok
);
    logic [N:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_cs
        assign hit[g] = level_ok(cs[g], cs_pol[g]);
    end
    assign hit[N] = level_ok(oe, oe_pol);

    // R5 every pin must sit at its active level
    assign sel_ok = &hit;
endmodule

// File: rtl/wmem_store.sv
module wmem_store
    import wmem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wipe,
    input  logic              wr_arr,
    input  logic              wr_cfg,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             din,
    output word_t             rd_word,
    output pol_t              pol
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];
    pol_t  pol_q;

    // R1 R2 array storage, blank value all ones
    always_ff @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_arr) begin
            mem[addr] <= din;
        end
    end

    // R4 R9 only the polarity bits are kept
    always_ff @(posedge clk) begin
        if (wipe)        pol_q <= '0;
        else if (wr_cfg) pol_q <= pol_from_word(din);
    end

    assign rd_word = mem[addr];
    assign pol     = pol_q;
endmodule

// File: rtl/cfgsel_word_mem.sv
module cfgsel_word_mem
    import wmem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        cs_in,
    input  logic              oe_in,
    input  logic              prog_mode,
    input  logic              pgm_stb,
    input  logic              vfy_stb,
    input  logic              cfg_sel,
    input  logic              erase,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic              drive_o,
    output logic              err_o
);
    op_e   op;
    logic  sel_ok;
    logic  wr_arr;
    logic  wr_cfg;
    word_t rd_word;
    pol_t  pol;
    word_t dout_q;
    logic  drive_q;
    logic  err_q;

    wmem_op_ctrl u_op (
        .prog_mode (prog_mode),
        .pgm_stb   (pgm_stb),
        .vfy_stb   (vfy_stb),
        .erase     (erase),
        .op        (op)
    );

    wmem_sel_decode #(.N(NUM_CS)) u_sel (
        .cs     (cs_in),
        .oe     (oe_in),
        .cs_pol (pol.cs_pol),
        .oe_pol (pol.oe_pol),
        .sel_ok (sel_ok)
    );

    // R6 R9 steer writes
    assign wr_arr = (op == OP_WRITE) && !cfg_sel;
    assign wr_cfg = (op == OP_WRITE) &&  cfg_sel;

    wmem_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wipe    (op == OP_WIPE),
        .wr_arr  (wr_arr),
        .wr_cfg  (wr_cfg),
        .addr    (addr),
        .din     (din),
        .rd_word (rd_word),
        .pol     (pol)
    );

    // R3 registered outputs, zero bus when not driven
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '0;
            drive_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (op == OP_CLASH);
            unique case (op)
                OP_READ: begin
                    drive_q <= sel_ok;
                    dout_q  <= sel_ok ? rd_word : '0;
                end
                OP_CHECK: begin
                    drive_q <= 1'b1;
                    dout_q  <= cfg_sel ? word_from_pol(pol) : rd_word;
                end
                default: begin
                    drive_q <= 1'b0;
                    dout_q  <= '0;
                end
            endcase
        end
    end

    assign dout    = dout_q;
    assign drive_o = drive_q;
    assign err_o   = err_q;
endmodule

// File: rtl/wmem_chk.sv
module wmem_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              prog_mode,
    input logic              pgm_stb,
    input logic              vfy_stb,
    input logic              erase,
    input logic [15:0]       dout,
    input logic              drive_o,
    input logic              err_o
);
    // R3
    bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_o |-> dout == 16'h0000);

    // R2
    wipe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        erase |=> !drive_o);

    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_mode && pgm_stb && !vfy_stb && !erase) |=> !drive_o);

    // R7
    check_drives_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_mode && vfy_stb && !pgm_stb && !erase) |=> drive_o);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_mode && !pgm_stb && !vfy_stb && !erase) |=> !drive_o);

    // R11
    clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_mode && pgm_stb && vfy_stb && !erase) |=> (err_o && !drive_o));

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(prog_mode && pgm_stb && vfy_stb && !erase));

    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (drive_o && $past(drive_o) && $past(addr) == $past(addr, 2)
         && !$past(erase, 2) && !$past(prog_mode, 2)) |-> $stable(dout));
endmodule

bind cfgsel_word_mem wmem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .prog_mode (prog_mode),
    .pgm_stb   (pgm_stb),
    .vfy_stb   (vfy_stb),
    .erase     (erase),
    .dout      (dout),
    .drive_o   (drive_o),
    .err_o     (err_o)
);

// File: tb/test_cfgsel_word_mem.sv
module test_cfgsel_word_mem;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [2:0]    cs_in = '0;
    logic          oe_in = 1'b0;
    logic          prog_mode = 1'b0;
    logic          pgm_stb = 1'b0;
    logic          vfy_stb = 1'b0;
    logic          cfg_sel = 1'b0;
    logic          erase = 1'b0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic          drive_o;
    logic          err_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    cfgsel_word_mem #(.ADDR_W(AW)) i_cfgsel_word_mem (
        .clk(clk), .rst(rst), .addr(addr), .cs_in(cs_in), .oe_in(oe_in),
        .prog_mode(prog_mode), .pgm_stb(pgm_stb), .vfy_stb(vfy_stb),
        .cfg_sel(cfg_sel), .erase(erase), .din(din), .dout(dout),
        .drive_o(drive_o), .err_o(err_o)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h2F1B) ^ 16'h5A3C);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: drive/dout actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_at(input int a, input logic [15:0] exp, input string req);
        addr = AW'(a);
        tick();
        check(req, {drive_o, dout}, {1'b1, exp});
    endtask

    task automatic write_cfg(input logic [15:0] w);
        prog_mode = 1; cfg_sel = 1; pgm_stb = 1; din = w;
        tick();
        pgm_stb = 0; cfg_sel = 0; prog_mode = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // R3 reset state
        check("R3", {drive_o, dout}, 17'h0);
        check("R11", {16'h0, err_o}, 17'h0);

        // R2 erase then blank reads with active-low selects
        erase = 1; tick();
        check("R2", {drive_o, dout}, 17'h0);
        erase = 0;
        for (int a = 0; a < DEPTH; a++) read_at(a, 16'hFFFF, "R2");

        // R6 program every word, bus stays quiet
        prog_mode = 1; pgm_stb = 1;
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a); din = pat(a); tick();
            check("R6", {drive_o, dout}, 17'h0);
        end
        pgm_stb = 0;

        // R7 verify ignores selects and output enable
        vfy_stb = 1;
        for (int a = 0; a < DEPTH; a++) begin
            cs_in = 3'(a + 5); oe_in = a[3];
            addr = AW'(a); tick();
            check("R7", {drive_o, dout}, {1'b1, pat(a)});
        end
        vfy_stb = 0; prog_mode = 0; cs_in = 0; oe_in = 0;

        // R1 R3 normal read-back, one-cycle latency
        for (int a = 0; a < DEPTH; a++) read_at(a, pat(a), "R1");

        // R4 R5 R9 every polarity setting against every pin pattern
        for (int c = 0; c < 16; c++) begin
            logic [15:0] cw;
            int hits;
            cw = (16'(c) << 12 & 16'h7000) >> 0;
            cw = {1'b0, 3'(c >> 1), 11'h0, 1'(c)};
            write_cfg(cw | (16'h8FFE & 16'(c * 16'h1357)));
            prog_mode = 1; cfg_sel = 1; vfy_stb = 1; tick();
            check("R9", {drive_o, dout}, {1'b1, cw});
            vfy_stb = 0; cfg_sel = 0; prog_mode = 0;
            hits = 0;
            for (int s = 0; s < 16; s++) begin
                logic want;
                int a;
                a = (c * 4 + s) % DEPTH;
                cs_in = 3'(s); oe_in = s[3]; addr = AW'(a);
                want = (3'(s) == 3'(c >> 1)) && (s[3] == c[0]);
                tick();
                check("R4", {drive_o, dout}, want ? {1'b1, pat(a)} : 17'h0);
                if (s[3] == c[0] && drive_o) hits++;
            end
            check("R5", 17'(hits), 17'd1);
        end
        write_cfg(16'h0000);
        cs_in = 0; oe_in = 0;
        read_at(3, pat(3), "R9");
        read_at(40, pat(40), "R9");

        // R8 inhibit writes nothing, drives nothing
        prog_mode = 1; addr = 5; din = 16'h1234; tick();
        check("R8", {drive_o, dout}, 17'h0);
        prog_mode = 0;
        read_at(5, pat(5), "R8");

        // R10 strobes outside programming mode
        pgm_stb = 1; din = 16'hBEEF; addr = 7; tick();
        check("R10", {drive_o, dout}, {1'b1, pat(7)});
        pgm_stb = 0;
        read_at(7, pat(7), "R10");

        // R11 clash: flag for one cycle, no write
        prog_mode = 1; pgm_stb = 1; vfy_stb = 1; addr = 9; din = 16'h0000; tick();
        check("R11", {err_o, drive_o, 15'h0}, {1'b1, 1'b0, 15'h0});
        pgm_stb = 0; vfy_stb = 0; prog_mode = 0; tick();
        check("R11", {16'h0, err_o}, 17'h0);
        read_at(9, pat(9), "R11");

        // R12 hold stable, then disable and move
        for (int k = 0; k < 4; k++) read_at(10, pat(10), "R12");
        cs_in = 3'b010; tick();
        check("R3", {drive_o, dout}, 17'h0);
        cs_in = 0;
        read_at(11, pat(11), "R12");

        // R2 erase after programming restores blank state and polarity
        write_cfg(16'h7001);
        erase = 1; tick(); erase = 0;
        prog_mode = 1; cfg_sel = 1; vfy_stb = 1; tick();
        check("R2", {drive_o, dout}, {1'b1, 16'h0000});
        vfy_stb = 0; cfg_sel = 0; prog_mode = 0;
        cs_in = 0; oe_in = 0;
        for (int a = 0; a < DEPTH; a += 7) read_at(a, 16'hFFFF, "R2");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule